// File: doc/BRIEF.md
# Sample-Rate Decimator With Optional Averaging

This block lowers the rate of a stream of 32-bit words by a programmable divider. Each word is either one 32-bit sample or two 16-bit samples packed side by side. Every input word first has its upper bits rebuilt from a programmable bit position. Those bits are either copies of the sign bit or zeros. In averaging mode the block sums a group of words and divides the sum by a right shift, so each group gives its mean. Without averaging it keeps the first word of each group and drops the rest.

In packed 16-bit mode the low and high halves are two independent lanes, and each lane is averaged on its own. The divider counts 16-bit samples in that mode, so a group spans half as many words. A change to the divider, the averaging switch or the width switch drops any group in progress and starts a new one. Changes to the sign settings take effect on the next word and do not restart the group.

Top module: `decim_avg`

## Requirements
- R1: After reset, out_valid is 0 and out_data is 0.
- R2: A divider of 0 behaves as a divider of 1. With a group of one word, every valid input word gives out_valid in the next cycle, with the extended word on out_data.
- R3: With averaging off and cfg_half=0, the group is N words (N = divider). After the N-th valid word, out_valid rises for one cycle and out_data is the extended first word of that group.
- R4: With averaging off and cfg_half=1, the group is N>>1 words, with a minimum of 1. An odd N rounds down to an even sample count. The first word of the group is output.
- R5: With averaging on, the group is 2^k words, where k = floor(log2 N) capped at 12. With cfg_half=0, out_data is the sum of the extended 32-bit samples shifted right arithmetically by k (the floor of the mean), low 32 bits.
- R6: With averaging on and cfg_half=1, the lane in bits 15:0 and the lane in bits 31:16 are each summed and shifted by k on their own. Each mean goes back to the bit positions of its lane.
- R7: With cfg_signed=1, every bit above position cfg_sign_pos takes the value of bit cfg_sign_pos. In 16-bit mode this applies per lane, and positions above 15 act as 15.
- R8: With cfg_signed=0, every bit above position cfg_sign_pos is cleared. The lanes and the clamp work as in R7.
- R9: A group of 4096 words of any value is summed without overflow. 4096 words of 0xFFFFFFFF unsigned give 0xFFFFFFFF. 4096 words of 0x80000000 signed give 0x80000000.
- R10: A change of divider, averaging or width discards the partial group, and counting restarts with the current word.
- R11: out_valid is high for exactly one cycle per completed group and only in the cycle after a valid input word. Cycles with in_valid=0 do not advance the group. out_data holds its value between outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | One 32-bit sample or two packed 16-bit samples |
| cfg_div | input | 16 | Rate divider N |
| cfg_avg | input | 1 | 1 = output group mean, 0 = keep first word |
| cfg_half | input | 1 | 0 = 32-bit samples, 1 = two 16-bit samples |
| cfg_signed | input | 1 | 0 = zero-fill upper bits, 1 = copy sign bit |
| cfg_sign_pos | input | 5 | Bit position the extension starts from |
| out_valid | output | 1 | One-cycle strobe per completed group |
| out_data | output | 32 | Decimated or averaged word |

## Verification
The bench builds the block with its default parameters: 32-bit words, a 16-bit divider and a cap of 12 on the averaging exponent. With these values a full 4096-word averaging group fits in a few thousand cycles, so the widest accumulator sum and the cap on the exponent can both be reached. Dividers far above that size are only covered through the way the group length is derived, not through full-length groups. Random data, random gaps in in_valid and changes of configuration in mid-group are checked against a word-level reference.

// File: rtl/decim_pkg.sv
package decim_pkg;

    // Width-mode encoding of the cfg_half input
    typedef enum logic {
        WMODE_32 = 1'b0,
        WMODE_16 = 1'b1
    } wmode_e;

    // Index of the highest set bit, 0 for a zero input
    function automatic int top_bit(input logic [31:0] v);
        int r;
        r = 0;
        for (int i = 0; i < 32; i++) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/decim_sign_ext.sv
module decim_sign_ext #(
    parameter int DATA_W  = 32,
    parameter int ACC_W   = 45,
    parameter int LACC_W  = 29
) (
    input  logic [DATA_W-1:0]          word_i,
    input  logic [$clog2(DATA_W)-1:0]  pos_i,
    input  logic                       sgn_i,
    input  logic                       half_i,
    output logic [DATA_W-1:0]          ext_word_o,
    output logic signed [ACC_W-1:0]    val0_o,
    output logic signed [LACC_W-1:0]   val1_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam int POS_W  = $clog2(DATA_W);
    localparam int HPOS_W = $clog2(HALF_W);

    logic [DATA_W-1:0] full_ext;
    logic [HALF_W-1:0] lane_ext [2];
    logic [HPOS_W-1:0] hpos;

    always_comb begin
        hpos = (pos_i > POS_W'(HALF_W - 1)) ? HPOS_W'(HALF_W - 1) : pos_i[HPOS_W-1:0];
        for (int i = 0; i < DATA_W; i++) begin
            full_ext[i] = (i > int'(pos_i)) ? (sgn_i & word_i[pos_i]) : word_i[i];
        end
    end

    for (genvar l = 0; l < 2; l++) begin : g_lane
        logic [HALF_W-1:0] raw;
        assign raw = word_i[l*HALF_W +: HALF_W];
        always_comb begin
            for (int i = 0; i < HALF_W; i++) begin
                lane_ext[l][i] = (i > int'(hpos)) ? (sgn_i & raw[hpos]) : raw[i];
            end
        end
    end

    always_comb begin
        if (half_i == decim_pkg::WMODE_16) begin
            ext_word_o = {lane_ext[1], lane_ext[0]};
            val0_o = {{(ACC_W-HALF_W){sgn_i & lane_ext[0][HALF_W-1]}}, lane_ext[0]};
            val1_o = {{(LACC_W-HALF_W){sgn_i & lane_ext[1][HALF_W-1]}}, lane_ext[1]};
        end else begin
            ext_word_o = full_ext;
            val0_o = {{(ACC_W-DATA_W){sgn_i & full_ext[DATA_W-1]}}, full_ext};
            val1_o = '0;
        end
    end
endmodule

// File: rtl/decim_group_len.sv
module decim_group_len #(
    parameter int DIV_W    = 16,
    parameter int MAX_LOG2 = 12,
    parameter int SH_W     = 4
) (
    input  logic [DIV_W-1:0] div_i,
    input  logic             avg_i,
    input  logic             half_i,
    output logic [DIV_W-1:0] grp_len_o,
    output logic [SH_W-1:0]  shift_o
);
    logic [DIV_W-1:0] n_eff;
    logic [DIV_W-1:0] n_half;
    int               k_raw;
    int               k_cap;

    always_comb begin
        n_eff  = (div_i == '0) ? DIV_W'(1) : div_i;
        n_half = n_eff >> 1;
        k_raw  = decim_pkg::top_bit(32'(n_eff));
        k_cap  = (k_raw > MAX_LOG2) ? MAX_LOG2 : k_raw;
        if (avg_i) begin
            grp_len_o = DIV_W'(1) << k_cap;
            shift_o   = SH_W'(k_cap);
        end else begin
            shift_o = '0;
            if (half_i == decim_pkg::WMODE_16)
                grp_len_o = (n_half == '0) ? DIV_W'(1) : n_half;
            else
                grp_len_o = n_eff;
        end
    end
endmodule

// File: rtl/decim_mean.sv
module decim_mean #(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 45,
    parameter int LACC_W = 29,
    parameter int SH_W   = 4
) (
    input  logic signed [ACC_W-1:0]  sum0_i,
    input  logic signed [LACC_W-1:0] sum1_i,
    input  logic [SH_W-1:0]          shift_i,
    input  logic                     half_i,
    output logic [DATA_W-1:0]        mean_o
);
    localparam int HALF_W = DATA_W / 2;

    logic signed [ACC_W-1:0]  q0;
    logic signed [LACC_W-1:0] q1;

    always_comb begin
        q0 = sum0_i >>> shift_i;
        q1 = sum1_i >>> shift_i;
        if (half_i == decim_pkg::WMODE_16)
            mean_o = {q1[HALF_W-1:0], q0[HALF_W-1:0]};
        else
            mean_o = q0[DATA_W-1:0];
    end
endmodule

// File: rtl/decim_avg.sv
module decim_avg #(
    parameter int DATA_W   = 32,
    parameter int DIV_W    = 16,
    parameter int MAX_LOG2 = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [DATA_W-1:0]         in_data,
    input  logic [DIV_W-1:0]          cfg_div,
    input  logic                      cfg_avg,
    input  logic                      cfg_half,
    input  logic                      cfg_signed,
    input  logic [$clog2(DATA_W)-1:0] cfg_sign_pos,
    output logic                      out_valid,
    output logic [DATA_W-1:0]         out_data
);
    localparam int HALF_W = DATA_W / 2;
    localparam int ACC_W  = DATA_W + MAX_LOG2 + 1;
    localparam int LACC_W = HALF_W + MAX_LOG2 + 1;
    localparam int SH_W   = $clog2(MAX_LOG2 + 1);

    typedef struct packed {
        logic [DIV_W-1:0]         cnt;
        logic signed [ACC_W-1:0]  acc0;
        logic signed [LACC_W-1:0] acc1;
        logic [DATA_W-1:0]        hold;
        logic [DIV_W-1:0]         div_prev;
        logic                     avg_prev;
        logic                     half_prev;
        logic                     out_valid;
        logic [DATA_W-1:0]        out_data;
    } state_t;

    state_t st_d, st_q;

    logic [DATA_W-1:0]         ext_word;
    logic signed [ACC_W-1:0]   val0;
    logic signed [LACC_W-1:0]  val1;
    logic [DIV_W-1:0]          grp_len;
    logic [SH_W-1:0]           shift;
    logic                      restart;
    logic [DIV_W-1:0]          base_cnt;
    logic signed [ACC_W-1:0]   base_acc0;
    logic signed [LACC_W-1:0]  base_acc1;
    logic signed [ACC_W-1:0]   sum0;
    logic signed [LACC_W-1:0]  sum1;
    logic [DATA_W-1:0]         mean;
    logic [DIV_W-1:0]          cnt_q;

    decim_sign_ext #(.DATA_W(DATA_W), .ACC_W(ACC_W), .LACC_W(LACC_W)) u_ext (
        .word_i(in_data), .pos_i(cfg_sign_pos), .sgn_i(cfg_signed), .half_i(cfg_half),
        .ext_word_o(ext_word), .val0_o(val0), .val1_o(val1)
    );

    decim_group_len #(.DIV_W(DIV_W), .MAX_LOG2(MAX_LOG2), .SH_W(SH_W)) u_len (
        .div_i(cfg_div), .avg_i(cfg_avg), .half_i(cfg_half),
        .grp_len_o(grp_len), .shift_o(shift)
    );

    assign restart   = (cfg_div != st_q.div_prev) || (cfg_avg != st_q.avg_prev)
                     || (cfg_half != st_q.half_prev);
    assign base_cnt  = restart ? '0 : st_q.cnt;
    assign base_acc0 = restart ? '0 : st_q.acc0;
    assign base_acc1 = restart ? '0 : st_q.acc1;
    assign sum0      = base_acc0 + val0;
    assign sum1      = base_acc1 + val1;
    assign cnt_q     = st_q.cnt;

    decim_mean #(.DATA_W(DATA_W), .ACC_W(ACC_W), .LACC_W(LACC_W), .SH_W(SH_W)) u_mean (
        .sum0_i(sum0), .sum1_i(sum1), .shift_i(shift), .half_i(cfg_half), .mean_o(mean)
    );

    always_comb begin
        st_d           = st_q;
        st_d.div_prev  = cfg_div;
        st_d.avg_prev  = cfg_avg;
        st_d.half_prev = cfg_half;
        st_d.out_valid = 1'b0;
        st_d.cnt       = base_cnt;
        st_d.acc0      = base_acc0;
        st_d.acc1      = base_acc1;
        if (in_valid) begin
            if (base_cnt == grp_len - DIV_W'(1)) begin
                st_d.out_valid = 1'b1;
                if (cfg_avg)
                    st_d.out_data = mean;
                else
                    st_d.out_data = (base_cnt == '0) ? ext_word : st_q.hold;
                st_d.cnt  = '0;
                st_d.acc0 = '0;
                st_d.acc1 = '0;
            end else begin
                st_d.cnt  = base_cnt + DIV_W'(1);
                st_d.acc0 = sum0;
                st_d.acc1 = sum1;
                if (base_cnt == '0) st_d.hold = ext_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.out_valid;
    assign out_data  = st_q.out_data;
endmodule

// File: rtl/decim_avg_chk.sv
module decim_avg_chk #(
    parameter int DATA_W = 32,
    parameter int DIV_W  = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic                      cfg_half,
    input logic                      cfg_signed,
    input logic [$clog2(DATA_W)-1:0] cfg_sign_pos,
    input logic                      out_valid,
    input logic [DATA_W-1:0]         out_data,
    input logic [DIV_W-1:0]          grp_len,
    input logic [DIV_W-1:0]          cnt_q,
    input logic                      restart
);
    localparam int POS_W = $clog2(DATA_W);

    function automatic logic upper_copies(input logic [DATA_W-1:0] d, input logic [POS_W-1:0] p);
        logic [DATA_W-1:0] t;
        t = $unsigned($signed(d) >>> p);
        return (t == '0) || (t == '1);
    endfunction

    function automatic logic upper_zero(input logic [DATA_W-1:0] d, input logic [POS_W-1:0] p);
        return ((d >> p) >> 1) == '0;
    endfunction

    AST_VALID_AFTER_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)); // R11

    AST_COUNT_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |-> (cnt_q < grp_len)); // R3

    AST_SINGLE_WORD_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && grp_len == DIV_W'(1)) |=> out_valid); // R2

    AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !in_valid) |=> (cnt_q == '0)); // R10

    AST_SIGNED_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_valid && grp_len == DIV_W'(1) && !cfg_half && cfg_signed))
        |-> upper_copies(out_data, $past(cfg_sign_pos))); // R7

    AST_UNSIGNED_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_valid && grp_len == DIV_W'(1) && !cfg_half && !cfg_signed))
        |-> upper_zero(out_data, $past(cfg_sign_pos))); // R8
endmodule

bind decim_avg decim_avg_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cfg_half(cfg_half),
    .cfg_signed(cfg_signed), .cfg_sign_pos(cfg_sign_pos), .out_valid(out_valid),
    .out_data(out_data), .grp_len(grp_len), .cnt_q(cnt_q), .restart(restart)
);

// File: tb/sim_decim_avg.sv
`timescale 1ns/1ps
module sim_decim_avg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic [15:0] cfg_div = '0;
    logic        cfg_avg = 1'b0, cfg_half = 1'b0, cfg_signed = 1'b0;
    logic [4:0]  cfg_sign_pos = '0;
    logic        out_valid;
    logic [31:0] out_data;

    decim_avg u0 (.*);

    always #5 clk = ~clk;

    // staged configuration, applied at the next tick
    logic [15:0] n_div = '0;
    logic        n_avg = 0, n_half = 0, n_sgn = 0;
    logic [4:0]  n_pos = '0;

    int checks = 0, fails = 0;
    string tag = "R1";

    // reference model state
    int          m_cnt = 0;
    longint      m_a0 = 0, m_a1 = 0;
    logic [31:0] m_hold = '0;
    logic [15:0] p_div = '0;
    logic        p_avg = 0, p_half = 0;
    logic        e_v = 0;
    logic [31:0] e_d = '0;

    function automatic longint ext_val(logic [31:0] x, int pos, bit sgn, int w);
        int p;
        logic [63:0] m;
        longint v;
        p = (pos > w - 1) ? w - 1 : pos;
        m = (64'd1 << (p + 1)) - 64'd1;
        v = longint'({32'd0, x} & m);
        if (sgn && x[p]) v = v - longint'(64'd1 << (p + 1));
        return v;
    endfunction

    function automatic logic [31:0] pack(longint a, longint b, bit half);
        logic [63:0] ua, ub;
        ua = a; ub = b;
        return half ? {ub[15:0], ua[15:0]} : ua[31:0];
    endfunction

    task automatic model_step(bit v, logic [31:0] d);
        int n0, k, g;
        longint v0, v1;
        if (cfg_div != p_div || cfg_avg != p_avg || cfg_half != p_half) begin
            m_cnt = 0; m_a0 = 0; m_a1 = 0;
        end
        p_div = cfg_div; p_avg = cfg_avg; p_half = cfg_half;
        n0 = (cfg_div == 0) ? 1 : int'(cfg_div);
        k = 0;
        while (k < 12 && (2 << k) <= n0) k++;
        if (cfg_avg) g = 1 << k;
        else if (cfg_half) g = (n0 / 2 == 0) ? 1 : n0 / 2;
        else g = n0;
        e_v = 0;
        if (v) begin
            if (cfg_half) begin
                v0 = ext_val({16'd0, d[15:0]}, cfg_sign_pos, cfg_signed, 16);
                v1 = ext_val({16'd0, d[31:16]}, cfg_sign_pos, cfg_signed, 16);
            end else begin
                v0 = ext_val(d, cfg_sign_pos, cfg_signed, 32);
                v1 = 0;
            end
            m_a0 += v0; m_a1 += v1;
            if (m_cnt == 0) m_hold = pack(v0, v1, cfg_half);
            if (m_cnt == g - 1) begin
                e_v = 1;
                e_d = cfg_avg ? pack(m_a0 >>> k, m_a1 >>> k, cfg_half) : m_hold;
                m_cnt = 0; m_a0 = 0; m_a1 = 0;
            end else m_cnt++;
        end
    endtask

    task automatic tick(bit v, logic [31:0] d);
        @(negedge clk);
        checks++;
        if (out_valid !== e_v || out_data !== e_d) begin
            fails++;
            $display("FAIL %s: out_valid=%0b out_data=%08h expected %0b %08h",
                     tag, out_valid, out_data, e_v, e_d);
        end
        cfg_div = n_div; cfg_avg = n_avg; cfg_half = n_half;
        cfg_signed = n_sgn; cfg_sign_pos = n_pos;
        in_valid = v; in_data = d;
        model_step(v, d);
    endtask

    task automatic run_random(int n, int gap_pct);
        for (int i = 0; i < n; i++) begin
            tick(($urandom % 100) >= gap_pct, $urandom);
        end
    endtask

    task automatic setcfg(int div, bit avg, bit half, bit sgn, int pos);
        n_div = 16'(div); n_avg = avg; n_half = half; n_sgn = sgn; n_pos = 5'(pos);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1"; tick(0, 0); tick(0, 0);

        tag = "R2"; setcfg(0, 0, 0, 1, 31); run_random(40, 20);
        setcfg(1, 1, 0, 0, 31); run_random(40, 0);

        tag = "R3/R11"; setcfg(5, 0, 0, 1, 31); run_random(300, 30);
        setcfg(65535, 0, 0, 0, 31); run_random(50, 0);

        tag = "R4"; setcfg(6, 0, 1, 1, 15); run_random(200, 25);
        setcfg(3, 0, 1, 0, 15); run_random(100, 25);
        setcfg(1, 0, 1, 1, 9); run_random(40, 0);

        tag = "R5"; setcfg(8, 1, 0, 1, 31); run_random(300, 30);
        setcfg(6, 1, 0, 0, 31); run_random(200, 10);
        setcfg(40000, 1, 0, 1, 20); run_random(4200, 5);

        tag = "R6"; setcfg(4, 1, 1, 1, 11); run_random(300, 20);
        setcfg(16, 1, 1, 0, 15); run_random(300, 10);

        tag = "R7"; setcfg(1, 0, 0, 1, 7); run_random(60, 10);
        tick(1, 32'h0000_0080); tick(1, 32'h1234_5601);
        setcfg(1, 0, 1, 1, 20); tick(1, 32'h8000_7FFF); run_random(40, 10);

        tag = "R8"; setcfg(1, 0, 0, 0, 7); run_random(60, 10);
        setcfg(2, 0, 1, 0, 3); run_random(60, 10);

        tag = "R9"; setcfg(4096, 1, 0, 0, 31);
        for (int i = 0; i < 4096; i++) tick(1, 32'hFFFF_FFFF);
        setcfg(4096, 1, 0, 1, 31);
        tick(0, 0);
        for (int i = 0; i < 4096; i++) tick(1, 32'h8000_0000);

        tag = "R10"; setcfg(8, 1, 0, 1, 31);
        for (int i = 0; i < 3; i++) tick(1, 32'd1000);
        setcfg(4, 1, 0, 1, 31);
        for (int i = 0; i < 4; i++) tick(1, 32'd8);
        setcfg(5, 0, 0, 0, 31);
        tick(1, 32'd77); tick(1, 32'd78);
        setcfg(5, 0, 1, 0, 31); run_random(30, 0);
        setcfg(5, 1, 1, 0, 31); tick(0, 0); run_random(30, 20);

        tag = "R11"; tick(0, 0); tick(0, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule